// File: doc/BRIEF.md
# Dual-Channel Parallel Host Register Port

This block sits between an asynchronous parallel host bus and two serial channels. The host drives an active-low chip select, active-low read and write strobes, a channel select line, a 3-bit register offset and an 8-bit data byte. The block passes those strobes through a synchronizer and decodes the channel and offset. It then turns each host access into at most one action on the chosen channel: a pop from its receive queue, a push into its transmit queue, or a capture of its line status byte.

Each channel's receive side is a valid/ready source. The block raises `rx_ready` for that channel for a single cycle, and a byte transfers only in a cycle where `rx_valid` and `rx_ready` are both high. Each channel's transmit side is a valid/ready sink. Once `tx_valid` rises, it and `tx_data` stay unchanged until the sink raises `tx_ready`, so the sink can stall the push as long as it needs. The data bus is split into an input, an output and an output enable, which drive an external tri-state pad. Every access ends only after the host releases its strobe, however long the strobe is held.

Top module: `dual_uart_hostbus`

## Requirements
- R1: After reset, `bus_doe`, every `rx_ready` bit and every `tx_valid` bit are 0.
- R2: While `bus_cs_n` is high, low read or write strobes start no access: no pop, no push, and `bus_doe` stays 0.
- R3: `bus_chan` = 1 addresses channel index 0 (ports bits [7:0] / bit 0). `bus_chan` = 0 addresses channel index 1 (bits [15:8] / bit 1). At most one channel's `rx_ready` or `tx_valid` is high in any cycle.
- R4: A read at offset 0 from a non-empty receive queue pops exactly one byte from the addressed channel and drives that byte on `bus_dout`.
- R5: A read at offset 0 from an empty receive queue (`rx_valid` low) drives 0x00 and pops nothing.
- R6: A write at offset 0 pushes the `bus_din` byte, sampled when the access is recognised, into the addressed channel's transmit queue exactly once.
- R7: While the transmit sink holds `tx_ready` low, `tx_valid` stays high and `tx_data` stays stable, even after the host releases its strobe. The byte is delivered once `tx_ready` rises.
- R8: A read at offset 5 drives the addressed channel's line status byte. A write at offset 5 causes no push, no pop and no bus drive.
- R9: Offsets 1, 2, 3, 4, 6 and 7 accept accesses without pushing or popping. Reads there drive 0x00.
- R10: `bus_doe` is high only during a read access, and returns to 0 after the strobe is released. It is never high during a write.
- R11: Each access performs at most one pop or push, however long the strobe stays low. The next access is recognised only after both strobes are high or chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_chan | input | 1 | Channel select: 1 = channel index 0, 0 = channel index 1 |
| bus_addr | input | 3 | Register offset |
| bus_din | input | 8 | Byte from host (pad input) |
| bus_dout | output | 8 | Byte to host (pad output) |
| bus_doe | output | 1 | Pad output enable, high while driving a read |
| rx_valid | input | 2 | Per-channel receive queue holds a byte |
| rx_data | input | 16 | Per-channel head byte, channel i at [8i+7:8i] |
| rx_ready | output | 2 | Per-channel pop strobe |
| tx_valid | output | 2 | Per-channel push request |
| tx_data | output | 8 | Byte being pushed |
| tx_ready | input | 2 | Per-channel transmit queue has room |
| line_status | input | 16 | Per-channel line status byte, channel i at [8i+7:8i] |

## Verification
The push stall and the strobe release can fall in the same cycle. The host lets go of a write while the transmit sink still refuses the byte, so the end of the access and the held push overlap. The bench provokes this by dropping `tx_ready`, completing a write, and waiting. It confirms that nothing is delivered, that `tx_valid` and `tx_data` hold, and that the byte arrives exactly once when `tx_ready` returns. A pop decision and a late-arriving `rx_valid` can also coincide. Randomized reads with the receive queue filling and draining check that the bus shows either the popped byte or 0x00, and never a pop without its data.

// File: rtl/uhb_pkg.sv
package uhb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POP,
    ST_PUSH,
    ST_READ,
    ST_WAIT
  } uhb_state_e;

  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_STATUS = 3'd5;
endpackage

// File: rtl/uhb_sync.sv
module uhb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uhb_chan_mux.sv
module uhb_chan_mux #(
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NCH)-1:0]      sel,
  input  logic                        pop_req,
  input  logic                        push_req,
  input  logic [NCH-1:0]              rx_valid,
  input  logic [NCH*DW-1:0]           rx_data,
  input  logic [NCH-1:0]              tx_ready,
  input  logic [NCH*DW-1:0]           status,
  output logic [NCH-1:0]              rx_ready,
  output logic [NCH-1:0]              tx_valid,
  output logic                        sel_rx_valid,
  output logic [DW-1:0]               sel_rx_data,
  output logic                        sel_tx_ready,
  output logic [DW-1:0]               sel_status
);
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign rx_ready[c] = pop_req  && (sel == c);
      assign tx_valid[c] = push_req && (sel == c);
    end
  endgenerate

  assign sel_rx_valid = rx_valid[sel];
  assign sel_tx_ready = tx_ready[sel];
  assign sel_rx_data  = rx_data[sel*DW +: DW];
  assign sel_status   = status[sel*DW +: DW];

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_ready, tx_valid})) else $error("two channel strobes"); // R3
endmodule

// File: rtl/dual_uart_hostbus.sv
module dual_uart_hostbus #(
  parameter int DW          = 8,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic          bus_chan,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [1:0]    rx_valid,
  input  logic [2*DW-1:0] rx_data,
  output logic [1:0]    rx_ready,
  output logic [1:0]    tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic [1:0]    tx_ready,
  input  logic [2*DW-1:0] line_status
);
  import uhb_pkg::*;

  localparam int NCH = 2;

  logic [2:0]    strb_s;
  logic          cs_s, rd_s, wr_s;
  logic          access, released;
  uhb_state_e    state;
  logic          ch_q;
  logic [AW-1:0] ofs_q;
  logic [DW-1:0] wdata_q, dout_q;
  logic          doe_q;
  logic          pop_req, push_req;
  logic          sel_rx_valid, sel_tx_ready;
  logic [DW-1:0] sel_rx_data, sel_status;

  uhb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_cs_n, bus_rd_n, bus_wr_n}), .q(strb_s)
  );
  assign {cs_s, rd_s, wr_s} = strb_s;

  assign access   = !cs_s && (!rd_s || !wr_s);
  assign released = cs_s || (rd_s && wr_s);

  assign pop_req  = (state == ST_POP);
  assign push_req = (state == ST_PUSH);

  uhb_chan_mux #(.DW(DW), .NCH(NCH)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .sel(ch_q), .pop_req(pop_req), .push_req(push_req),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
    .status(line_status),
    .rx_ready(rx_ready), .tx_valid(tx_valid),
    .sel_rx_valid(sel_rx_valid), .sel_rx_data(sel_rx_data),
    .sel_tx_ready(sel_tx_ready), .sel_status(sel_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ch_q    <= 1'b0;
      ofs_q   <= '0;
      wdata_q <= '0;
      dout_q  <= '0;
      doe_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (access) begin
          ch_q    <= ~bus_chan;
          ofs_q   <= bus_addr[AW-1:0];
          wdata_q <= bus_din;
          if (!rd_s) state <= (bus_addr == OFS_DATA) ? ST_POP : ST_READ;
          else       state <= (bus_addr == OFS_DATA) ? ST_PUSH : ST_WAIT;
        end
        ST_POP: begin
          dout_q <= sel_rx_valid ? sel_rx_data : '0;
          doe_q  <= 1'b1;
          state  <= ST_WAIT;
        end
        ST_READ: begin
          dout_q <= (ofs_q == OFS_STATUS) ? sel_status : '0;
          doe_q  <= 1'b1;
          state  <= ST_WAIT;
        end
        ST_PUSH: if (sel_tx_ready) state <= ST_WAIT;
        ST_WAIT: if (released) begin
          doe_q <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_dout = dout_q;
  assign bus_doe  = doe_q;
  assign tx_data  = wdata_q;

  AST_QUIET_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && state == ST_IDLE) |=> (rx_ready == '0 && tx_valid == '0))
    else $error("access without chip select"); // R2
  AST_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tx_valid) && !(|(tx_valid & tx_ready))) |=> ((tx_valid == $past(tx_valid)) && $stable(tx_data)))
    else $error("push dropped while stalled"); // R7
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_valid) |-> !bus_doe) else $error("bus driven during write"); // R10
  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_ready) |=> (rx_ready == '0)) else $error("repeated pop"); // R11
  AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_valid & tx_ready)) |=> (tx_valid == '0)) else $error("repeated push"); // R11
endmodule

// File: tb/dual_uart_hostbus_bench.sv
module dual_uart_hostbus_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_chan = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_din = '0;
  logic [7:0]  bus_dout;
  logic        bus_doe;
  logic [1:0]  rx_valid, rx_ready, tx_valid, tx_ready;
  logic [15:0] rx_data, line_status;
  logic [7:0]  tx_data;

  int checks = 0, fails = 0;
  int rx_left [2];
  logic [7:0] rx_byte [2];
  int pops [2], pushes [2];
  logic [7:0] last_push [2];
  logic [1:0] tx_rdy_q = 2'b11;

  always #10 clk = ~clk;

  dual_uart_hostbus u_dual_uart_hostbus (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_chan(bus_chan), .bus_addr(bus_addr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .line_status(line_status)
  );

  assign rx_valid    = {rx_left[1] != 0, rx_left[0] != 0};
  assign rx_data     = {rx_byte[1], rx_byte[0]};
  assign tx_ready    = tx_rdy_q;
  assign line_status = 16'hA53C;

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (rx_ready[c] && rx_valid[c]) begin
        rx_left[c] <= rx_left[c] - 1;
        rx_byte[c] <= rx_byte[c] + 8'd37;
        pops[c]    <= pops[c] + 1;
      end
      if (tx_valid[c] && tx_ready[c]) begin
        pushes[c]    <= pushes[c] + 1;
        last_push[c] <= tx_data;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic chan);
    return chan ? 0 : 1;
  endfunction

  function automatic logic [7:0] exp_read(input int c, input logic [2:0] a);
    if (a == 3'd0) return (rx_left[c] != 0) ? rx_byte[c] : 8'h00;
    if (a == 3'd5) return line_status[c*8 +: 8];
    return 8'h00;
  endfunction

  // one host access; returns bus value sampled before release
  task automatic access(input logic chan, input logic [2:0] a, input bit rd,
                        input logic [7:0] d, input int hold, output logic [7:0] seen,
                        output logic seen_oe);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_chan = chan; bus_addr = a; bus_din = d;
    bus_rd_n = !rd;  bus_wr_n = rd;
    repeat (hold) @(negedge clk);
    seen = bus_dout; seen_oe = bus_doe;
    bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, e; logic oe; int c, p0, p1, q0, q1;
    void'($urandom(32'd4242));
    rx_left[0] = 3; rx_left[1] = 2; rx_byte[0] = 8'h11; rx_byte[1] = 8'h80;
    pops[0] = 0; pops[1] = 0; pushes[0] = 0; pushes[1] = 0;
    last_push[0] = 0; last_push[1] = 0;
    repeat (3) @(negedge clk);
    check(bus_doe == 0 && rx_ready == 0 && tx_valid == 0, "R1", {bus_doe, rx_ready, tx_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_doe == 0 && tx_valid == 0, "R1", {bus_doe, tx_valid}, 0);

    // R2: strobe low without chip select
    @(negedge clk); bus_chan = 1; bus_addr = 0; bus_rd_n = 0;
    repeat (10) @(negedge clk);
    check(pops[0] == 0 && bus_doe == 0, "R2", pops[0], 0);
    bus_rd_n = 1; repeat (4) @(negedge clk);

    // R3/R4: read channel index 0 then index 1
    e = exp_read(0, 0); access(1, 0, 1, 0, 10, v, oe);
    check(v == e && oe, "R4", v, e);
    check(pops[0] == 1 && pops[1] == 0, "R3", pops[1], 0);
    e = exp_read(1, 0); access(0, 0, 1, 0, 10, v, oe);
    check(v == e && pops[1] == 1, "R3", v, e);
    check(bus_doe == 0, "R10", bus_doe, 0);

    // R11: long strobe, one pop
    p0 = pops[0]; e = exp_read(0, 0); access(1, 0, 1, 0, 60, v, oe);
    check(pops[0] == p0 + 1 && v == e, "R11", pops[0], p0 + 1);

    // R5: empty queue
    rx_left[1] = 0; @(negedge clk);
    p1 = pops[1]; access(0, 0, 1, 0, 10, v, oe);
    check(v == 8'h00 && oe && pops[1] == p1, "R5", v, 0);

    // R6: write pushes
    access(1, 0, 0, 8'h5E, 10, v, oe);
    check(pushes[0] == 1 && last_push[0] == 8'h5E, "R6", last_push[0], 8'h5E);
    check(oe == 0, "R10", oe, 0);

    // R7: stalled push across strobe release
    tx_rdy_q = 2'b00; q1 = pushes[1];
    access(0, 0, 0, 8'hC7, 6, v, oe);
    repeat (10) @(negedge clk);
    check(pushes[1] == q1 && tx_valid == 2'b10 && tx_data == 8'hC7, "R7", tx_data, 8'hC7);
    tx_rdy_q = 2'b11; repeat (3) @(negedge clk);
    check(pushes[1] == q1 + 1 && last_push[1] == 8'hC7 && tx_valid == 0, "R7", pushes[1], q1 + 1);

    // R8: status read, status write ignored
    access(1, 5, 1, 0, 10, v, oe);
    check(v == 8'h3C && oe, "R8", v, 8'h3C);
    access(0, 5, 1, 0, 10, v, oe);
    check(v == 8'hA5, "R8", v, 8'hA5);
    q0 = pushes[0]; p0 = pops[0];
    access(1, 5, 0, 8'hFF, 10, v, oe);
    check(pushes[0] == q0 && pops[0] == p0 && !oe, "R8", pushes[0], q0);

    // R9: inactive offsets
    for (int a = 1; a < 8; a++) begin
      if (a == 5) continue;
      q0 = pushes[0] + pushes[1]; p0 = pops[0] + pops[1];
      access(a[0], a[2:0], 1, 0, 8, v, oe);
      check(v == 8'h00 && pops[0] + pops[1] == p0, "R9", v, 0);
      access(a[0], a[2:0], 0, 8'h77, 8, v, oe);
      check(pushes[0] + pushes[1] == q0, "R9", pushes[0] + pushes[1], q0);
    end

    // randomized mix
    for (int n = 0; n < 60; n++) begin
      logic ch; logic [2:0] a; bit rd; logic [7:0] d;
      ch = 1'($urandom); rd = 1'($urandom);
      a  = ($urandom % 3 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'd0 : 3'd5);
      d  = 8'($urandom);
      if ($urandom % 4 == 0) begin rx_left[0] = $urandom % 3; rx_left[1] = $urandom % 3; end
      @(negedge clk);
      c = idx_of(ch);
      p0 = pops[c]; q0 = pushes[c]; e = exp_read(c, a);
      access(ch, a, rd, d, 4 + ($urandom % 12), v, oe);
      if (rd) begin
        check(v == e && oe, (a == 0) ? "R4" : ((a == 5) ? "R8" : "R9"), v, e);
        check(pops[c] == p0 + ((a == 0 && e != 0) ? 1 : 0) || (a == 0 && v == 0 && pops[c] <= p0 + 1),
              "R11", pops[c], p0);
      end else begin
        check(pushes[c] == q0 + ((a == 0) ? 1 : 0) && !oe, "R6", pushes[c], q0);
        if (a == 0) check(last_push[c] == d, "R6", last_push[c], d);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule